// File: doc/BRIEF.md
# Cipher Engine FIFO Control Interface

This block is the control front end of a cipher engine that has an input FIFO and an output FIFO. It holds a memory-mapped control word and a DMA enable word on a simple register bus. The control word carries the engine enable, a write-only flush strobe, a key-size field, a data-type field, a three-bit algorithm mode and a direction bit. The block also keeps the read pointer, write pointer and fill count of both FIFOs, and it clears them when a flush is accepted.

A DMA controller moves data into the input FIFO and out of the output FIFO in bursts of at most four words. For each FIFO the block raises a request line when a four-word burst fits. The request stays latched until the controller pulses the matching clear line, and it cannot be raised again until that clear has gone low. The requests drop as soon as the engine or the matching channel enable is switched off. When the core signals that key preparation has ended, the block turns the engine enable off by itself.

Top module: `cefc_top`

## Requirements
- R1: After reset both registers read as zero, all FIFO pointers and counts are zero, and both DMA requests are low.
- R2: Word address 0 holds the control word: enable at bit 15, key size at bits 7:6, data type at bits 5:4, algorithm mode at bits 3:1, direction at bit 0. Word address 1 holds input DMA enable at bit 0 and output DMA enable at bit 1. All other bits read as zero and ignore writes.
- R3: Bit 14 of the control word (flush) always reads as 0. Writing 1 to it while the engine is disabled (enable value before the write) sets pointers and counts of both FIFOs to zero at that clock edge.
- R4: Writing 0 to the flush bit, or writing any flush value while the engine is enabled, leaves all pointers and counts unchanged.
- R5: A key-done strobe while the algorithm mode is 111b clears the enable bit at that edge and wins over a same-cycle bus write of enable = 1. A key-done strobe in any other mode has no effect.
- R6: The input request rises on the clock edge after the engine is enabled, input DMA is enabled, at least four input FIFO entries are free and the input clear line is low.
- R7: The output request rises on the clock edge after the engine is enabled, output DMA is enabled, at least four words sit in the output FIFO and the output clear line is low.
- R8: A raised request stays high until its clear line is high at a clock edge, is low from that edge on while the clear stays high, and can rise again at the earliest on the second edge after the clear falls.
- R9: Clearing the engine enable drops both requests, and clearing a channel's DMA enable drops only that channel's request, right after the write's clock edge.
- R10: When both requests would rise at the same edge, only the output request rises; the input request may rise at the following edge.
- R11: A push into a full FIFO and a pop from an empty FIFO are ignored; pointers wrap from depth-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| key_done | input | 1 | Key preparation finished strobe from the core |
| in_push | input | 1 | Word written into the input FIFO |
| in_pop | input | 1 | Word taken from the input FIFO by the core |
| out_push | input | 1 | Word written into the output FIFO by the core |
| out_pop | input | 1 | Word taken from the output FIFO |
| in_wptr | output | clog2(DEPTH) | Input FIFO write pointer |
| in_rptr | output | clog2(DEPTH) | Input FIFO read pointer |
| in_count | output | clog2(DEPTH)+1 | Input FIFO fill count |
| out_wptr | output | clog2(DEPTH) | Output FIFO write pointer |
| out_rptr | output | clog2(DEPTH) | Output FIFO read pointer |
| out_count | output | clog2(DEPTH)+1 | Output FIFO fill count |
| in_dma_req | output | 1 | Input FIFO DMA request |
| in_dma_clr | input | 1 | Input FIFO DMA clear |
| out_dma_req | output | 1 | Output FIFO DMA request |
| out_dma_clr | input | 1 | Output FIFO DMA clear |
| eng_en | output | 1 | Engine enable to the core |
| key_size | output | 2 | Key size selection |
| data_type | output | 2 | Data type selection |
| algo_mode | output | 3 | Algorithm mode |
| algo_dir | output | 1 | Direction |

## Verification
A wrong request state shows within one or two cycles at the request pins: a channel stuck in its wait state never re-raises after the clear falls, and a lost latch drops the request before any clear arrives. A wrong fill count shows as a request threshold off by one entry, which the sweep over every fill level from empty to full exposes at once. A wrong enable or flush decision shows on the next readback of the control word or as pointers that fail to return to zero after the write edge.

// File: rtl/cefc_pkg.sv
package cefc_pkg;

  localparam int EN_BIT    = 15;
  localparam int FLUSH_BIT = 14;

  localparam logic [2:0] MODE_KEYPREP = 3'b111;

  typedef struct packed {
    logic       en;
    logic [1:0] ksize;
    logic [1:0] dtype;
    logic [2:0] mode;
    logic       dir;
  } ctrl_t;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_REQ  = 2'd1,
    CH_HOLD = 2'd2
  } ch_state_t;

endpackage

// File: rtl/cefc_regs.sv
module cefc_regs
  import cefc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              key_done,
  output logic [31:0]       bus_rdata,
  output ctrl_t             ctrl,
  output logic              in_dma_en,
  output logic              out_dma_en,
  output logic              flush_pulse
);

  ctrl_t      ctrl_q, ctrl_d;
  logic       ctrl_ld;
  logic [1:0] dma_q, dma_d;
  logic       dma_ld;
  logic       wr_ctrl, wr_dma, kd_clear;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(0));
    wr_dma   = bus_wr && (bus_addr == ADDR_W'(1));
    kd_clear = key_done && (ctrl_q.mode == MODE_KEYPREP);

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en    = bus_wdata[EN_BIT];
      ctrl_d.ksize = bus_wdata[7:6];
      ctrl_d.dtype = bus_wdata[5:4];
      ctrl_d.mode  = bus_wdata[3:1];
      ctrl_d.dir   = bus_wdata[0];
    end
    // hardware clear wins over a same-cycle software set
    if (kd_clear) ctrl_d.en = 1'b0;
    ctrl_ld = wr_ctrl || kd_clear;

    dma_d  = bus_wdata[1:0];
    dma_ld = wr_dma;

    // flush accepted only while the engine was off before this write
    flush_pulse = wr_ctrl && bus_wdata[FLUSH_BIT] && !ctrl_q.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ld) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= '0;
    end else if (dma_ld) begin
      dma_q <= dma_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0)) begin
      bus_rdata[EN_BIT] = ctrl_q.en;
      bus_rdata[7:6]    = ctrl_q.ksize;
      bus_rdata[5:4]    = ctrl_q.dtype;
      bus_rdata[3:1]    = ctrl_q.mode;
      bus_rdata[0]      = ctrl_q.dir;
    end else if (bus_addr == ADDR_W'(1)) begin
      bus_rdata[1:0] = dma_q;
    end
  end

  assign ctrl       = ctrl_q;
  assign in_dma_en  = dma_q[0];
  assign out_dma_en = dma_q[1];

  AST_KEYPREP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (key_done && ctrl_q.mode == MODE_KEYPREP) |=> !ctrl_q.en); // R5

endmodule

// File: rtl/cefc_fifo_ptrs.sv
module cefc_fifo_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic                     pop,
  output logic [$clog2(DEPTH)-1:0] wptr,
  output logic [$clog2(DEPTH)-1:0] rptr,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop, ld;

  always_comb begin
    do_push = push && (cnt_q != FULL);
    do_pop  = pop  && (cnt_q != '0);
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
    ld = flush || do_push || do_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ld) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && wptr_q == '0 && rptr_q == '0)); // R3

endmodule

// File: rtl/cefc_dma_ch.sv
module cefc_dma_ch
  import cefc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic cond,
  input  logic clr,
  input  logic block,
  output logic req,
  output logic rising
);

  ch_state_t st_q, st_d;
  logic      st_ld;

  always_comb begin
    st_d   = st_q;
    rising = 1'b0;
    if (!gate) begin
      st_d = CH_IDLE;
    end else begin
      case (st_q)
        CH_IDLE: if (cond && !clr && !block) begin
          st_d   = CH_REQ;
          rising = 1'b1;
        end
        CH_REQ:  if (clr)  st_d = CH_HOLD;
        CH_HOLD: if (!clr) st_d = CH_IDLE;
        default: st_d = CH_IDLE;
      endcase
    end
    st_ld = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CH_IDLE;
    end else if (st_ld) begin
      st_q <= st_d;
    end
  end

  assign req = (st_q == CH_REQ) && gate;

  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr) |=> (req || !gate)); // R8

  AST_CLR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req); // R8

endmodule

// File: rtl/cefc_top.sv
module cefc_top
  import cefc_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BURST  = 4,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     key_done,
  input  logic                     in_push,
  input  logic                     in_pop,
  input  logic                     out_push,
  input  logic                     out_pop,
  output logic [$clog2(DEPTH)-1:0] in_wptr,
  output logic [$clog2(DEPTH)-1:0] in_rptr,
  output logic [$clog2(DEPTH):0]   in_count,
  output logic [$clog2(DEPTH)-1:0] out_wptr,
  output logic [$clog2(DEPTH)-1:0] out_rptr,
  output logic [$clog2(DEPTH):0]   out_count,
  output logic                     in_dma_req,
  input  logic                     in_dma_clr,
  output logic                     out_dma_req,
  input  logic                     out_dma_clr,
  output logic                     eng_en,
  output logic [1:0]               key_size,
  output logic [1:0]               data_type,
  output logic [2:0]               algo_mode,
  output logic                     algo_dir
);

  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

  logic  rst_meta, rst_sync_n;
  ctrl_t ctrl;
  logic  in_dma_en, out_dma_en, flush_pulse;
  logic  in_cond, out_cond, out_rising, in_rising;
  logic  [CNT_W-1:0] in_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cefc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .key_done   (key_done),
    .bus_rdata  (bus_rdata),
    .ctrl       (ctrl),
    .in_dma_en  (in_dma_en),
    .out_dma_en (out_dma_en),
    .flush_pulse(flush_pulse)
  );

  cefc_fifo_ptrs #(.DEPTH(DEPTH)) u_in_fifo (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .flush(flush_pulse),
    .push (in_push),
    .pop  (in_pop),
    .wptr (in_wptr),
    .rptr (in_rptr),
    .count(in_count)
  );

  cefc_fifo_ptrs #(.DEPTH(DEPTH)) u_out_fifo (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .flush(flush_pulse),
    .push (out_push),
    .pop  (out_pop),
    .wptr (out_wptr),
    .rptr (out_rptr),
    .count(out_count)
  );

  always_comb begin
    in_free  = FULL_C - in_count;
    in_cond  = (in_free >= BURST_C);
    out_cond = (out_count >= BURST_C);
  end

  cefc_dma_ch u_out_ch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .gate  (ctrl.en && out_dma_en),
    .cond  (out_cond),
    .clr   (out_dma_clr),
    .block (1'b0),
    .req   (out_dma_req),
    .rising(out_rising)
  );

  cefc_dma_ch u_in_ch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .gate  (ctrl.en && in_dma_en),
    .cond  (in_cond),
    .clr   (in_dma_clr),
    .block (out_rising),
    .req   (in_dma_req),
    .rising(in_rising)
  );

  assign eng_en    = ctrl.en;
  assign key_size  = ctrl.ksize;
  assign data_type = ctrl.dtype;
  assign algo_mode = ctrl.mode;
  assign algo_dir  = ctrl.dir;

  AST_OUT_BEFORE_IN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(in_dma_req) |-> !$rose(out_dma_req)); // R10

  AST_IN_RISE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_rising |=> in_dma_req); // R6

endmodule

// File: tb/cefc_top_test.sv
module cefc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 2;
  localparam int PW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              key_done, in_push, in_pop, out_push, out_pop;
  logic [PW-1:0]     in_wptr, in_rptr, out_wptr, out_rptr;
  logic [PW:0]       in_count, out_count;
  logic              in_dma_req, in_dma_clr, out_dma_req, out_dma_clr;
  logic              eng_en, algo_dir;
  logic [1:0]        key_size, data_type;
  logic [2:0]        algo_mode;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cefc_top #(.DEPTH(DEPTH), .BURST(4), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_done(key_done),
    .in_push(in_push), .in_pop(in_pop), .out_push(out_push), .out_pop(out_pop),
    .in_wptr(in_wptr), .in_rptr(in_rptr), .in_count(in_count),
    .out_wptr(out_wptr), .out_rptr(out_rptr), .out_count(out_count),
    .in_dma_req(in_dma_req), .in_dma_clr(in_dma_clr),
    .out_dma_req(out_dma_req), .out_dma_clr(out_dma_clr),
    .eng_en(eng_en), .key_size(key_size), .data_type(data_type),
    .algo_mode(algo_mode), .algo_dir(algo_dir)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-CTRL FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    bus_addr = ADDR_W'(a);
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic push_in(input int n);
    for (int i = 0; i < n; i++) begin in_push = 1'b1; @(negedge clk); end
    in_push = 1'b0;
  endtask

  task automatic push_out(input int n);
    for (int i = 0; i < n; i++) begin out_push = 1'b1; @(negedge clk); end
    out_push = 1'b0;
  endtask

  task automatic pop_in(input int n);
    for (int i = 0; i < n; i++) begin in_pop = 1'b1; @(negedge clk); end
    in_pop = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_bad++;
        $display("FIFO-CTRL FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    key_done = 1'b0; in_push = 1'b0; in_pop = 1'b0; out_push = 1'b0; out_pop = 1'b0;
    in_dma_clr = 1'b0; out_dma_clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    rd(0, 32'h0, "R1 ctrl reset");
    rd(1, 32'h0, "R1 dma reset");
    check("R1 pointers", {in_wptr, in_rptr, out_wptr, out_rptr}, '0);
    check("R1 counts", {in_count, out_count}, '0);
    check("R1 requests", {in_dma_req, out_dma_req}, 2'b00);

    // R2 field sweep with reserved bits set; enable and flush kept 0
    for (int v = 0; v < 256; v++) begin
      wr(0, 32'hFFFF_3F00 | 32'(v));
      rd(0, 32'(v), "R2 ctrl readback");
    end
    check("R2 mode out", algo_mode, 3'b111);
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h3, "R2 dma readback");
    wr(1, 32'h0);
    rd(2, 32'h0, "R2 unused address");

    // R11 overflow, underflow, wrap
    push_in(10);
    check("R11 full count", in_count, DEPTH);
    check("R11 wrap wptr", in_wptr, 0);
    pop_in(10);
    check("R11 empty count", in_count, 0);
    check("R11 wrap rptr", in_rptr, 0);

    // R3 flush while disabled; flush reads as 0
    push_in(5); push_out(3);
    wr(0, 32'h0000_4000);
    check("R3 flush in", {in_wptr, in_rptr, in_count}, '0);
    check("R3 flush out", {out_wptr, out_rptr, out_count}, '0);
    rd(0, 32'h0, "R3 flush reads zero");

    // R4 flush 0 while disabled, flush 1 while enabled
    push_in(3); push_out(2);
    wr(0, 32'h0000_0000);
    check("R4 flush zero", {in_count, out_count}, {4'(3), 4'(2)});
    wr(0, 32'h0000_8000);
    wr(0, 32'h0000_C000);
    check("R4 flush while enabled", {in_count, out_count, in_wptr}, {4'(3), 4'(2), 3'(3)});
    rd(0, 32'h0000_8000, "R4 enable kept");

    // R5 key done in mode 111b and in another mode
    wr(0, 32'h0000_800E);
    key_done = 1'b1; @(negedge clk); key_done = 1'b0;
    check("R5 keydone clears", eng_en, 1'b0);
    rd(0, 32'h0000_000E, "R5 readback");
    bus_wr = 1'b1; bus_addr = '0; bus_wdata = 32'h0000_800E; key_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; key_done = 1'b0;
    check("R5 hw clear wins", eng_en, 1'b0);
    wr(0, 32'h0000_8006);
    key_done = 1'b1; @(negedge clk); key_done = 1'b0;
    check("R5 other mode ignored", eng_en, 1'b1);
    wr(0, 32'h0);
    wr(0, 32'h0000_4000);

    // R6 R7 thresholds over every fill level
    for (int k = 0; k <= DEPTH; k++) begin
      wr(0, 32'h0000_4000);
      push_in(k); push_out(k);
      wr(1, 32'h3);
      wr(0, 32'h0000_8000);
      tick(3);
      check("R7 out threshold", out_dma_req, (k >= 4));
      check("R6 in threshold", in_dma_req, ((DEPTH - k) >= 4));
      wr(0, 32'h0);
    end

    // R10 priority: both conditions met, enable together
    wr(0, 32'h0000_4000);
    push_out(4);
    wr(1, 32'h3);
    wr(0, 32'h0000_8000);
    check("R10 nothing yet", {out_dma_req, in_dma_req}, 2'b00);
    @(negedge clk);
    check("R10 out first", {out_dma_req, in_dma_req}, 2'b10);
    @(negedge clk);
    check("R10 in next", {out_dma_req, in_dma_req}, 2'b11);

    // R8 latch, clear, re-arm on input channel
    tick(3);
    check("R8 held without clear", in_dma_req, 1'b1);
    in_dma_clr = 1'b1; @(negedge clk);
    check("R8 drop on clear", in_dma_req, 1'b0);
    tick(2);
    check("R8 low while clear high", in_dma_req, 1'b0);
    in_dma_clr = 1'b0; @(negedge clk);
    check("R8 not yet after clear falls", in_dma_req, 1'b0);
    @(negedge clk);
    check("R8 re-raised", in_dma_req, 1'b1);
    check("R8 out unaffected", out_dma_req, 1'b1);

    // R9 channel enable and engine enable gating
    wr(1, 32'h2);
    check("R9 in dma off", {out_dma_req, in_dma_req}, 2'b10);
    wr(1, 32'h3);
    tick(2);
    check("R9 in back", in_dma_req, 1'b1);
    wr(0, 32'h0);
    check("R9 engine off", {out_dma_req, in_dma_req}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule